// File: doc/BRIEF.md
# Cascadable Toggle-Chain Up/Down Counter

This block is an N-bit synchronous binary counter built from identical one-bit toggle cells. A toggle-enable ripples from the least significant cell to the most significant one. Each cell passes the enable on only when its own state bit has the value that produces a carry in the current direction: 1 when counting up, 0 when counting down. The enable entering the least significant cell is tied high. A counting edge therefore toggles every bit up to and including the lowest bit that does not carry.

All cells share the synchronous controls: clock enable, clear, load select, count enable and direction. They also share two asynchronous controls. The asynchronous reset forces the count to zero. The asynchronous load copies the parallel data input into the count, independent of the clock. The enable leaving the top cell becomes a terminal-count flag, qualified by count enable. It is split into a carry output, meaning the count is at maximum going up, and a borrow output, meaning the count is at zero going down. These outputs let a neighbouring counter extend the width.

Top module: `tgl_chain_counter`

## Requirements
- R1: While `rst_n` is low, `q` is 0 at once, without waiting for a clock edge. Reset overrides every other input.
- R2: While `aload` is high and `rst_n` is high, `q` takes the value of `din` at once, without waiting for a clock edge. All synchronous controls are ignored.
- R3: A rising clock edge with `clk_en` low leaves `q` unchanged. This holds whatever the values of `sclr`, `ld_sel`, `cnt_en`, `dir_up` and `din`.
- R4: A rising clock edge with `clk_en` high and `sclr` high sets `q` to 0. Clear has priority over load and count.
- R5: A rising clock edge with `clk_en` high, `sclr` low and `ld_sel` high loads `din` into `q`. This happens whatever the value of `cnt_en`.
- R6: A rising clock edge with `clk_en`, `cnt_en` and `dir_up` high and `sclr` and `ld_sel` low sets `q` to (q+1) mod 2^N. The all-ones value wraps to 0.
- R7: The same edge with `dir_up` low sets `q` to (q-1) mod 2^N. The value 0 wraps to all-ones.
- R8: In count mode (`ld_sel` low, `sclr` low) with `cnt_en` low, an enabled clock edge leaves `q` unchanged.
- R9: `tc` is combinational. It is high exactly when `cnt_en` is high and `q` is at the terminal value for the current direction: all-ones when `dir_up` is 1, zero when `dir_up` is 0.
- R10: `carry` equals `tc` while `dir_up` is 1, and `borrow` equals `tc` while `dir_up` is 0. The other output is low in each case.
- R11: A change of `dir_up` in the middle of a count takes effect on the very next enabled count edge, starting from the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset to zero, active low |
| aload | input | 1 | Asynchronous parallel load of `din`, active high |
| clk_en | input | 1 | Gates every synchronous action |
| sclr | input | 1 | Synchronous clear |
| ld_sel | input | 1 | 1 = synchronous load, 0 = count |
| cnt_en | input | 1 | Enables counting and qualifies `tc` |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| din | input | N | Parallel data for both load paths |
| q | output | N | Count value |
| tc | output | 1 | Terminal count for the current direction |
| carry | output | 1 | Terminal count while counting up |
| borrow | output | 1 | Terminal count while counting down |

## Verification
On every clock edge the assertions check the behaviour of each cell: a hold when the clock is disabled, a load of its data bit, and a toggle when the incoming enable is set. At the top level they check that `carry` and `borrow` appear only on all-ones and zero respectively, that clear zeroes the count, and that an up count from the carry state wraps to zero. Only the bench scenarios can show the behaviour of the whole chain. These scenarios cover wraparound in both directions, a direction change in mid-count, and async reset or load asserted between clock edges. The bench checks all of these against an integer reference model.

// File: rtl/tgl_chain_pkg.sv
package tgl_chain_pkg;

  // The state polarity that lets the toggle enable pass on
  function automatic logic chain_bit(input logic st, input logic up);
    return up ? st : ~st;
  endfunction

  // The terminal flag split into its up and down outputs
  function automatic logic [1:0] split_term(input logic term, input logic up);
    return {term & up, term & ~up};
  endfunction

endpackage

// File: rtl/tgl_chain_cell.sv
module tgl_chain_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic aload,
  input  logic d,
  input  logic t_in,
  input  logic clk_en,
  input  logic sclr,
  input  logic ld_sel,
  input  logic cnt_en,
  input  logic dir_up,
  output logic q,
  output logic t_out
);
  import tgl_chain_pkg::*;

  // Named internal events, used by the assertions
  logic hold_evt, load_evt, toggle_evt;
  assign hold_evt   = ~clk_en;
  assign load_evt   = clk_en & ~sclr & ld_sel;
  assign toggle_evt = clk_en & ~sclr & ~ld_sel & cnt_en & t_in;

  always_ff @(posedge clk or negedge rst_n or posedge aload) begin
    if (!rst_n)        q <= 1'b0;
    else if (aload)    q <= d;
    else if (clk_en) begin
      if (sclr)        q <= 1'b0;
      else if (ld_sel) q <= d;
      else if (cnt_en && t_in) q <= ~q;
    end
  end

  assign t_out = t_in & chain_bit(q, dir_up);

  // R3
  cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || aload)
    ($past(rst_n) && !$past(aload) && $past(hold_evt)) |-> (q == $past(q)));
  // R5
  cell_load_chk: assert property (@(posedge clk) disable iff (!rst_n || aload)
    ($past(rst_n) && !$past(aload) && $past(load_evt)) |-> (q == $past(d)));
  // R6 R7
  cell_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n || aload)
    ($past(rst_n) && !$past(aload) && $past(toggle_evt)) |-> (q != $past(q)));
endmodule

// File: rtl/tgl_chain_status.sv
module tgl_chain_status (
  input  logic msb_t,
  input  logic cnt_en,
  input  logic dir_up,
  output logic tc,
  output logic carry,
  output logic borrow
);
  import tgl_chain_pkg::*;

  logic [1:0] split;
  assign tc    = msb_t & cnt_en;
  assign split = split_term(tc, dir_up);
  assign carry  = split[1];
  assign borrow = split[0];
endmodule

// File: rtl/tgl_chain_counter.sv
module tgl_chain_counter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         aload,
  input  logic         clk_en,
  input  logic         sclr,
  input  logic         ld_sel,
  input  logic         cnt_en,
  input  logic         dir_up,
  input  logic [N-1:0] din,
  output logic [N-1:0] q,
  output logic         tc,
  output logic         carry,
  output logic         borrow
);
  localparam int MSB = N - 1;

  // Serial toggle-enable chain; entry of the lowest cell is tied high
  logic [N:0] tchain;
  assign tchain[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_cell
    tgl_chain_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .aload  (aload),
      .d      (din[i]),
      .t_in   (tchain[i]),
      .clk_en (clk_en),
      .sclr   (sclr),
      .ld_sel (ld_sel),
      .cnt_en (cnt_en),
      .dir_up (dir_up),
      .q      (q[i]),
      .t_out  (tchain[i+1])
    );
  end

  tgl_chain_status u_status (
    .msb_t  (tchain[MSB+1]),
    .cnt_en (cnt_en),
    .dir_up (dir_up),
    .tc     (tc),
    .carry  (carry),
    .borrow (borrow)
  );

  logic up_wrap_evt, clr_evt;
  assign up_wrap_evt = carry & clk_en & ~sclr & ~ld_sel;
  assign clr_evt     = clk_en & sclr;

  // R10
  carry_max_chk: assert property (@(posedge clk) disable iff (!rst_n || aload)
    carry |-> ((&q) && dir_up && cnt_en));
  // R10
  borrow_min_chk: assert property (@(posedge clk) disable iff (!rst_n || aload)
    borrow |-> ((q == '0) && !dir_up && cnt_en));
  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || aload)
    ($past(rst_n) && !$past(aload) && $past(clr_evt)) |-> (q == '0));
  // R6
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n || aload)
    ($past(rst_n) && !$past(aload) && $past(up_wrap_evt)) |-> (q == '0));
endmodule

// File: tb/sim_tgl_chain_counter.sv
module sim_tgl_chain_counter;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0, rst_n = 1'b0, aload = 1'b0;
  logic clk_en = 1'b0, sclr = 1'b0, ld_sel = 1'b0, cnt_en = 1'b0, dir_up = 1'b1;
  logic [W-1:0] din = '0;
  wire  [W-1:0] q;
  wire tc, carry, borrow;

  int total = 0, bad = 0, exp_q = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tgl_chain_counter #(.N(W)) u0 (
    .clk(clk), .rst_n(rst_n), .aload(aload), .clk_en(clk_en), .sclr(sclr),
    .ld_sel(ld_sel), .cnt_en(cnt_en), .dir_up(dir_up), .din(din),
    .q(q), .tc(tc), .carry(carry), .borrow(borrow)
  );

  function automatic int ref_next(int cur, bit en, bit clr, bit ld, bit ce, bit up, int d);
    if (!en) return cur;
    if (clr) return 0;
    if (ld)  return d;
    if (!ce) return cur;
    return up ? (cur + 1) % M : (cur + M - 1) % M;
  endfunction

  function automatic bit ref_term(int cur, bit ce, bit up);
    return ce && (up ? (cur == M - 1) : (cur == 0));
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(bit en, bit clr, bit ld, bit ce, bit up, int d, string tag_o = "");
    string tag;
    bit t;
    clk_en = en; sclr = clr; ld_sel = ld; cnt_en = ce; dir_up = up; din = d[W-1:0];
    #1;
    t = ref_term(exp_q, ce, up);
    chk("R9 tc", tc, t);
    chk("R10 carry", carry, t && up);
    chk("R10 borrow", borrow, t && !up);
    tag = !en ? "R3 hold" : clr ? "R4 clear" : ld ? "R5 load" :
          !ce ? "R8 no count" : up ? "R6 up" : "R7 down";
    if (tag_o != "") tag = tag_o;
    exp_q = ref_next(exp_q, en, clr, ld, ce, up, d);
    @(posedge clk);
    #1;
    chk(tag, q, exp_q);
  endtask

  task automatic async_rst();
    #2; rst_n = 1'b0;
    #1; chk("R1 async reset", q, 0);
    @(posedge clk);
    #2; rst_n = 1'b1;
    exp_q = 0;
    chk("R1 after release", q, 0);
  endtask

  task automatic async_ld(int d);
    din = d[W-1:0];
    clk_en = 1'b0;
    #2; aload = 1'b1;
    #1; chk("R2 async load", q, d);
    @(posedge clk);
    #2; aload = 1'b0;
    exp_q = d;
    chk("R2 after release", q, d);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1;
    chk("R1 reset state", q, 0);
    chk("R9 tc at reset", tc, 0);
    @(posedge clk);
    @(posedge clk);
    #1; rst_n = 1'b1;
    chk("R1 reset held", q, 0);

    // Up wrap from near maximum
    cyc(1, 0, 1, 0, 1, M - 2);
    cyc(1, 0, 0, 1, 1, 0);
    cyc(1, 0, 0, 1, 1, 0, "R6 wrap to zero");
    cyc(1, 0, 0, 1, 1, 0);
    // Down wrap through zero
    cyc(1, 0, 1, 1, 0, 1, "R5 load with count enable");
    cyc(1, 0, 0, 1, 0, 0);
    cyc(1, 0, 0, 1, 0, 0, "R7 wrap to all-ones");
    cyc(1, 0, 0, 1, 0, 0);
    // Direction change in mid-count
    cyc(1, 0, 0, 1, 1, 0, "R11 turn up");
    cyc(1, 0, 0, 1, 1, 0);
    cyc(1, 0, 0, 1, 0, 0, "R11 turn down");
    // Hold cases and priorities
    cyc(0, 1, 1, 1, 1, 9, "R3 hold despite clear");
    cyc(1, 0, 0, 0, 1, 3, "R8 count disabled");
    cyc(1, 1, 1, 1, 1, 7, "R4 clear over load");
    cyc(1, 0, 1, 0, 0, 5, "R5 load without count enable");
    // Async events between edges
    async_ld(M - 1);
    cyc(1, 0, 0, 1, 1, 0, "R2 then count");
    async_rst();
    cyc(1, 0, 0, 1, 0, 0, "R1 then count down");

    for (int k = 0; k < 3000; k++) begin
      cyc(($urandom % 8) != 0, ($urandom % 16) == 0, ($urandom % 8) == 0,
          ($urandom % 4) != 0, $urandom % 2, $urandom % M);
      if (($urandom % 64) == 0) async_ld($urandom % M);
      if (($urandom % 97) == 0) async_rst();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule